// File: doc/BRIEF.md
# Hybrid Harmonic-Elimination PWM Leg Sequencer

This block produces the three-level switching state for one leg of a neutral-point-clamped inverter. The pattern comes from a table of precomputed switching angles that covers one quarter of the fundamental. A phase accumulator advances by a programmable step every clock. Its two top bits give the quarter. The remaining bits give the position inside that quarter. The full cycle is built from the single quarter table by quarter-wave symmetry: the second and fourth quarters mirror the position, and the second half of the cycle negates the level.

Two angle tables are held. One is a conventional pattern that keeps the triplen harmonics and so offers the higher modulation index. The other is a modified pattern that removes the low-order triplens and so lowers the common-mode voltage. The block compares a commanded frequency word with a threshold to decide which table is wanted. A change of table only takes effect when the accumulator wraps, which is the positive-going zero crossing at the end of a whole fundamental cycle. A one-cycle pulse marks that instant.

Software may rewrite angles only in the table that is not driving the leg. The angles are written as in-quarter positions in strictly ascending order.

Top module: `hshe_pwm_seq`

## Requirements
- R1: On a synchronous active-high reset the phase becomes zero, the conventional table is active (`scheme_mod` = 0), `cycle_start` is 0 and `leg_state` shows the zero level.
- R2: `leg_state` encodes the three levels as 2'b01 = positive rail (+1), 2'b00 = midpoint (0) and 2'b11 = negative rail (-1). The code 2'b10 never appears.
- R3: The phase is a PHASE_W-bit accumulator that adds `phase_inc` modulo 2^PHASE_W on every clock out of reset. Bits [PHASE_W-1:PHASE_W-2] are the quarter (0..3) and the lower PHASE_W-2 bits are the in-quarter position.
- R4: In quarter 0 the magnitude is the parity of the number of active-table angles that are less than or equal to the position. The level therefore starts at 0 and toggles between 0 and +1 at every angle crossing.
- R5: In quarters 1 and 3 the position used for the comparison is the bitwise complement of the in-quarter bits, which mirrors the quarter about pi/2.
- R6: In quarters 2 and 3 a nonzero magnitude is output as -1 instead of +1. Quarters 0 and 1 never produce -1.
- R7: Each clock the block registers a pending request. The request is conventional when `freq_word` >= `freq_thresh` (unsigned), including equality, and modified otherwise.
- R8: The active table changes only at a clock edge where the phase addition carries out of PHASE_W bits. At that edge it takes the pending request held before that edge. `cycle_start` is 1 for exactly the cycle after each such edge.
- R9: A write (`tbl_wr_en`, with `tbl_wr_sel` 0 = conventional and 1 = modified, entry `tbl_wr_idx`) is ignored when it addresses the active table. When it addresses the inactive table, the entry takes the new angle at that edge.
- R10: Reset loads both tables with evenly spaced angles: entry i = floor((i+1) * 2^(PHASE_W-2) / (N_ANG+1)).
- R11: When a write and a table switchover fall on the same edge, the write is accepted or refused against the table that was active before that edge. A write to the incoming table is therefore accepted and governs the output from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_inc | input | PHASE_W (32) | Phase step added each clock |
| freq_word | input | FREQ_W (16) | Commanded fundamental frequency |
| freq_thresh | input | FREQ_W (16) | Frequency at or above which the conventional table is wanted |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_sel | input | 1 | Table addressed: 0 conventional, 1 modified |
| tbl_wr_idx | input | IDX_W (4) | Angle entry addressed |
| tbl_wr_angle | input | PHASE_W-2 (30) | In-quarter angle value |
| leg_state | output | 2 | Leg level: 01 = +1, 00 = 0, 11 = -1 |
| scheme_mod | output | 1 | 1 when the modified table is active |
| cycle_start | output | 1 | One-cycle pulse after a fundamental wrap |

## Verification
Two functions of this block can meet on one edge: the switchover at an accumulator wrap and a table write. The bench waits until its own phase model shows that the next addition will carry. On that edge it writes a new angle into the table that is about to become active. It then sweeps the following quarter and expects the fresh angle to shape the waveform. The bench also moves the frequency request across the threshold in mid-cycle, sets it exactly equal to the threshold, and uses steps large enough to wrap on nearly every clock. These cases show that the request seen at each wrap decides the table and that each wrap gives its own `cycle_start` pulse.

// File: rtl/hshe_pkg.sv
package hshe_pkg;

    typedef enum logic {
        SCH_CONV = 1'b0,
        SCH_MOD  = 1'b1
    } scheme_e;

    typedef enum logic [1:0] {
        LVL_ZERO = 2'b00,
        LVL_POS  = 2'b01,
        LVL_NEG  = 2'b11
    } level_e;

    // Evenly spaced reset angle for entry idx of a table with nang entries,
    // inside a quarter of 2**qbits positions.
    function automatic logic [63:0] default_angle(input int idx, input int nang, input int qbits);
        logic [63:0] num;
        num = (64'(idx) + 64'd1) << qbits;
        return num / 64'(nang + 1);
    endfunction

    function automatic level_e make_level(input logic mag, input logic negative);
        if (!mag)
            return LVL_ZERO;
        else if (negative)
            return LVL_NEG;
        else
            return LVL_POS;
    endfunction

endpackage

// File: rtl/hshe_phase_acc.sv
module hshe_phase_acc #(
    parameter int PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] step,
    output logic [PHASE_W-1:0] phase,
    output logic               wrap
);
    logic [PHASE_W:0] sum;

    assign sum  = {1'b0, phase} + {1'b0, step};
    assign wrap = sum[PHASE_W];

    always_ff @(posedge clk) begin
        if (rst)
            phase <= '0;
        else
            phase <= sum[PHASE_W-1:0];
    end
endmodule

// File: rtl/hshe_scheme_ctl.sv
module hshe_scheme_ctl
    import hshe_pkg::*;
#(
    parameter int FREQ_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FREQ_W-1:0] freq_word,
    input  logic [FREQ_W-1:0] freq_thresh,
    input  logic              wrap,
    output scheme_e           active,
    output logic              cycle_start
);
    scheme_e pending;
    logic    seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending     <= SCH_CONV;
            active      <= SCH_CONV;
            cycle_start <= 1'b0;
            seen_q      <= 1'b0;
        end else begin
            pending     <= (freq_word >= freq_thresh) ? SCH_CONV : SCH_MOD;
            cycle_start <= wrap;
            seen_q      <= 1'b1;
            if (wrap)
                active <= pending;
        end
    end

    // The active table may only differ from its previous value right after a wrap.
    assert_switch_at_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (seen_q && (active != $past(active))) |-> cycle_start);
endmodule

// File: rtl/hshe_angle_bank.sv
module hshe_angle_bank
    import hshe_pkg::*;
#(
    parameter int N_ANG = 9,
    parameter int AW    = 30,
    parameter int IW    = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  scheme_e                   active,
    input  logic                      wr_en,
    input  scheme_e                   wr_sel,
    input  logic [IW-1:0]             wr_idx,
    input  logic [AW-1:0]             wr_angle,
    output logic [N_ANG-1:0][AW-1:0]  sel_tbl
);
    logic [N_ANG-1:0][AW-1:0] tbl_conv;
    logic [N_ANG-1:0][AW-1:0] tbl_mod;
    logic                     wr_ok;
    logic                     seen_q;

    assign wr_ok = wr_en && (wr_sel != active);

    for (genvar g = 0; g < N_ANG; g++) begin : g_entry
        localparam logic [AW-1:0] RST_ANG = AW'(default_angle(g, N_ANG, AW));
        logic hit;
        assign hit = wr_ok && (wr_idx == IW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                tbl_conv[g] <= RST_ANG;
                tbl_mod[g]  <= RST_ANG;
            end else if (hit) begin
                if (wr_sel == SCH_CONV)
                    tbl_conv[g] <= wr_angle;
                else
                    tbl_mod[g]  <= wr_angle;
            end
        end
    end

    assign sel_tbl = (active == SCH_MOD) ? tbl_mod : tbl_conv;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= 1'b1;
    end

    // A table that was driving the leg over an edge keeps its contents.
    assert_active_conv_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (seen_q && $past(active) == SCH_CONV) |-> $stable(tbl_conv));
    assert_active_mod_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (seen_q && $past(active) == SCH_MOD) |-> $stable(tbl_mod));
endmodule

// File: rtl/hshe_level_gen.sv
module hshe_level_gen
    import hshe_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int N_ANG   = 9,
    parameter int AW      = PHASE_W - 2
) (
    input  logic [PHASE_W-1:0]        phase,
    input  logic [N_ANG-1:0][AW-1:0]  tbl,
    output level_e                    level
);
    logic [1:0]       quarter;
    logic [AW-1:0]    local_pos;
    logic [AW-1:0]    eff_pos;
    logic [N_ANG-1:0] crossed;

    assign quarter   = phase[PHASE_W-1 -: 2];
    assign local_pos = phase[AW-1:0];
    assign eff_pos   = quarter[0] ? ~local_pos : local_pos;

    for (genvar g = 0; g < N_ANG; g++) begin : g_cmp
        assign crossed[g] = (eff_pos >= tbl[g]);
    end

    assign level = make_level(^crossed, quarter[1]);
endmodule

// File: rtl/hshe_pwm_seq.sv
module hshe_pwm_seq
    import hshe_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int N_ANG   = 9,
    parameter int FREQ_W  = 16,
    parameter int IDX_W   = $clog2(N_ANG)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] phase_inc,
    input  logic [FREQ_W-1:0]  freq_word,
    input  logic [FREQ_W-1:0]  freq_thresh,
    input  logic               tbl_wr_en,
    input  logic               tbl_wr_sel,
    input  logic [IDX_W-1:0]   tbl_wr_idx,
    input  logic [PHASE_W-3:0] tbl_wr_angle,
    output logic [1:0]         leg_state,
    output logic               scheme_mod,
    output logic               cycle_start
);
    localparam int AW = PHASE_W - 2;

    logic [PHASE_W-1:0]       phase_q;
    logic                     wrap;
    scheme_e                  active;
    logic [N_ANG-1:0][AW-1:0] act_tbl;
    level_e                   level;
    logic                     seen_q;

    hshe_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .step  (phase_inc),
        .phase (phase_q),
        .wrap  (wrap)
    );

    hshe_scheme_ctl #(.FREQ_W(FREQ_W)) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .freq_word   (freq_word),
        .freq_thresh (freq_thresh),
        .wrap        (wrap),
        .active      (active),
        .cycle_start (cycle_start)
    );

    hshe_angle_bank #(.N_ANG(N_ANG), .AW(AW), .IW(IDX_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .wr_en    (tbl_wr_en),
        .wr_sel   (scheme_e'(tbl_wr_sel)),
        .wr_idx   (tbl_wr_idx),
        .wr_angle (tbl_wr_angle),
        .sel_tbl  (act_tbl)
    );

    hshe_level_gen #(.PHASE_W(PHASE_W), .N_ANG(N_ANG), .AW(AW)) u_lvl (
        .phase (phase_q),
        .tbl   (act_tbl),
        .level (level)
    );

    assign leg_state  = level;
    assign scheme_mod = active;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= 1'b1;
    end

    assert_legal_level_R2: assert property (@(posedge clk) disable iff (rst)
        leg_state != 2'b10);

    assert_q0_nonneg_R6: assert property (@(posedge clk) disable iff (rst)
        (phase_q[PHASE_W-1 -: 2] == 2'b00) |-> (leg_state != LVL_NEG));

    // After a wrap the new phase is the remainder, smaller than the step used.
    assert_wrap_low_phase_R8: assert property (@(posedge clk) disable iff (rst)
        (seen_q && cycle_start) |-> (phase_q < $past(phase_inc)));
endmodule

// File: tb/hshe_pwm_seq_tb.sv
`timescale 1ns/1ps
module hshe_pwm_seq_tb;
    localparam int PW   = 12;
    localparam int NA   = 9;
    localparam int FW   = 16;
    localparam int IW   = 4;
    localparam int QN   = 1 << (PW - 2);
    localparam int FULL = 1 << PW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [PW-1:0] inc = '0;
    logic [FW-1:0] freq = 16'd50;
    logic [FW-1:0] thr = 16'd45;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [PW-3:0] wr_ang = '0;
    logic [1:0]    leg_state;
    logic          scheme_mod;
    logic          cycle_start;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    int m_phase = 0;
    int m_active = 0;
    int m_pend = 0;
    int m_cs = 0;
    int m_tbl [2][NA];

    always #10 clk = ~clk;

    hshe_pwm_seq #(.PHASE_W(PW), .N_ANG(NA), .FREQ_W(FW), .IDX_W(IW)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .phase_inc    (inc),
        .freq_word    (freq),
        .freq_thresh  (thr),
        .tbl_wr_en    (wr_en),
        .tbl_wr_sel   (wr_sel),
        .tbl_wr_idx   (wr_idx),
        .tbl_wr_angle (wr_ang),
        .leg_state    (leg_state),
        .scheme_mod   (scheme_mod),
        .cycle_start  (cycle_start)
    );

    // Expected level from R4, R5, R6 with the R2 encoding.
    function automatic logic [1:0] exp_level();
        int q, loc, pos, cnt;
        q   = m_phase / QN;
        loc = m_phase % QN;
        pos = (q % 2 == 1) ? (QN - 1 - loc) : loc;
        cnt = 0;
        for (int i = 0; i < NA; i++)
            if (m_tbl[m_active][i] <= pos) cnt++;
        if (cnt % 2 == 0) return 2'b00;
        return (q >= 2) ? 2'b11 : 2'b01;
    endfunction

    task automatic model_update();
        int sum;
        if (rst) begin
            m_phase = 0; m_active = 0; m_pend = 0; m_cs = 0;
            for (int t = 0; t < 2; t++)
                for (int i = 0; i < NA; i++)
                    m_tbl[t][i] = ((i + 1) * QN) / (NA + 1);   // R10
        end else begin
            if (wr_en && int'(wr_sel) != m_active && int'(wr_idx) < NA)
                m_tbl[int'(wr_sel)][int'(wr_idx)] = int'(wr_ang);
            sum  = m_phase + int'(inc);
            m_cs = (sum >= FULL) ? 1 : 0;
            if (m_cs == 1) m_active = m_pend;
            m_pend  = (freq >= thr) ? 0 : 1;
            m_phase = sum % FULL;
        end
    endtask

    task automatic check(input string tag);
        logic [1:0] el;
        el = exp_level();
        vectors++;
        if (leg_state !== el || scheme_mod !== 1'(m_active) || cycle_start !== 1'(m_cs)) begin
            fails++;
            $display("FAIL %s phase=%0d: leg=%b mod=%b cs=%b expected leg=%b mod=%0d cs=%0d",
                     tag, m_phase, leg_state, scheme_mod, cycle_start, el, m_active, m_cs);
        end
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        #1;
        model_update();
        @(negedge clk);
        check(tag);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    task automatic wr(input logic sel, input int idx, input int ang, input string tag);
        wr_en  = 1'b1;
        wr_sel = sel;
        wr_idx = IW'(idx);
        wr_ang = (PW-2)'(ang);
        cyc(tag);
        wr_en  = 1'b0;
    endtask

    initial begin
        run(2, "R1 reset");
        rst = 1'b0;
        run(2, "R1 idle after reset");

        // Full conventional fundamental at unit step over the reset tables.
        inc = PW'(1);
        run(FULL, "R2 R3 R4 R5 R6 R10 sweep");

        // Fill the inactive modified table.
        for (int i = 0; i < NA; i++) wr(1'b1, i, 40 + i * 100, "R9 inactive write");
        // Write into the active conventional table: must be ignored.
        wr(1'b0, 0, 5, "R9 active write ignored");
        wr(1'b0, 8, 1000, "R9 active write ignored");
        run(1200, "R9 conv output unchanged");

        // Request the modified scheme; switch happens only at the wrap.
        inc  = PW'(5);
        freq = 16'd42;
        run(1700, "R7 R8 switch to modified");
        freq = 16'd45;
        run(1700, "R7 equality selects conventional");
        freq = 16'd44;
        run(1700, "R7 R8 back to modified");

        // Active modified table is write-protected.
        wr(1'b1, 3, 1, "R9 active write ignored");
        run(900, "R9 mod output unchanged");

        // Rewrite the inactive conventional table.
        for (int i = 0; i < NA; i++) wr(1'b0, i, 100 + i * 90, "R9 inactive write");

        // Request flips during the cycle; the last value before the wrap wins.
        freq = 16'd50; run(100, "R7 R8 toggle");
        freq = 16'd40; run(100, "R7 R8 toggle");
        freq = 16'd50; run(100, "R7 R8 toggle");
        freq = 16'd40; run(1700, "R7 R8 toggle");

        // Write into the incoming table on the very edge of the switchover.
        freq = 16'd50;
        cyc("R7 request");
        while (m_phase + int'(inc) < FULL) cyc("R8 approach wrap");
        wr(1'b0, 4, 777, "R11 write on switch edge");
        run(1000, "R11 new angle governs");

        // Large steps: frequent wraps, request alternating.
        inc = PW'(1500);
        for (int k = 0; k < 20; k++) begin
            freq = (k % 2 == 0) ? 16'd30 : 16'd60;
            run(7, "R3 R8 large step");
        end
        inc = PW'(FULL - 1);
        run(40, "R8 wrap every cycle");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule